// File: doc/BRIEF.md
# Byte-wide host to 16-bit IDE register bridge

This block lets an 8-bit processor bus reach a 16-bit IDE/ATA device in PIO mode. The host opens a small I/O window with an active-low select. Inside that window one address bit chooses between the device registers and a pair of high-byte holding registers. The host's read/write line then picks one of four access kinds. The next address bit chooses the command block or the control block chip select. The three lowest bits pass straight through as the device register address.

A 16-bit transfer to the data port is done in two steps. For a write, the host first loads the upper byte into the write-high holder. It then writes the low byte to the device register, and the bridge drives both halves onto the IDE data bus. For a read, the host reads the low byte from the device register; the upper byte is captured on every device read. It then reads the read-high holder before it starts the next device read.

The read and write strobes are qualified by the host select and by a copy of the bus-phase signal that passes through `PHASE_DLY` registers. The strobes therefore assert only after the address lines have had time to settle.

Top module: `ide_byte_bridge`

## Requirements
- R1: With `hst_sel_n`=0 and `hst_addr[4]`=0, exactly one IDE chip select is low: `ide_cs0_n` when `hst_addr[3]`=0, `ide_cs1_n` when `hst_addr[3]`=1. `ide_da` always equals `hst_addr[2:0]`.
- R2: Both chip selects stay high whenever `hst_sel_n`=1 or `hst_addr[4]`=1.
- R3: An access is active while `hst_sel_n`=0 and the phase input, delayed by `PHASE_DLY` clock edges, is 1. With `PHASE_DLY`=1, a phase that rises between two rising edges first enables strobes after the next rising edge. Strobes clear at the edge after the phase falls, and clear at once when `hst_sel_n` rises.
- R4: An active access with `hst_addr[4]`=0 drives `ide_iow_n` low when `hst_rnw`=0 and `ide_ior_n` low when `hst_rnw`=1. The two strobes are never low together.
- R5: While `ide_iow_n` is low, `ide_dd_oe`=1 and `ide_dd_out` = {write-high byte, `hst_wdata`}. At all other times `ide_dd_oe`=0 and `ide_dd_out`=0.
- R6: An active access with `hst_addr[4]`=1 and `hst_rnw`=0 loads `hst_wdata` into the write-high byte. It produces no IDE strobe.
- R7: At every rising edge where `ide_ior_n` is low, `ide_dd_in[15:8]` is stored in the read-high byte. An active access with `hst_addr[4]`=1 and `hst_rnw`=1 returns that byte.
- R8: `hst_rdata_oe`=1 only during an active IDE read or an active read-high access. In those two cases `hst_rdata` is `ide_dd_in[7:0]` or the read-high byte. Otherwise `hst_rdata_oe`=0 and `hst_rdata`=0.
- R9: `ide_cs0_n` and `ide_cs1_n` are never low at the same time.
- R10: Reset clears both high-byte holders to 0, and all strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_sel_n | input | 1 | Host I/O window select, active low |
| hst_phase | input | 1 | Host bus-phase signal, high during the data phase |
| hst_rnw | input | 1 | Host direction, 1 = read |
| hst_addr | input | 5 | Host window address: [4] latch/IDE, [3] block, [2:0] register |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte |
| hst_rdata_oe | output | 1 | Host data bus drive enable |
| ide_cs0_n | output | 1 | Command block select, active low |
| ide_cs1_n | output | 1 | Control block select, active low |
| ide_da | output | 3 | IDE register address |
| ide_ior_n | output | 1 | IDE read strobe, active low |
| ide_iow_n | output | 1 | IDE write strobe, active low |
| ide_dd_out | output | 16 | Value driven onto the IDE data bus |
| ide_dd_oe | output | 1 | IDE data bus drive enable |
| ide_dd_in | input | 16 | Value sampled from the IDE data bus |

## Verification
The bench builds the bridge with its default parameters: an 8-bit host, a 3-bit register address and one phase delay register. The whole 5-bit host window is therefore small enough to sweep in both directions, twice, with different data patterns. Every combination of block bit, register address and latch-or-IDE choice is decoded and checked. Because the sweep interleaves latch loads, device reads and latch reads, each high-byte value is also checked as it is carried from one access to the next. Separate runs toggle the phase while the bridge is deselected and drop the select in the middle of an access.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;
   typedef enum logic [2:0] {
      ACC_IDLE   = 3'd0,
      ACC_IDE_WR = 3'd1,
      ACC_IDE_RD = 3'd2,
      ACC_HI_LD  = 3'd3,
      ACC_HI_RD  = 3'd4
   } acc_kind_e;
endpackage

// File: rtl/ide_addr_dec.sv
module ide_addr_dec #(
   parameter int REG_AW = 3
) (
   input  logic              sel_n,
   input  logic [REG_AW+1:0] addr,
   output logic              cs0_n,
   output logic              cs1_n,
   output logic [REG_AW-1:0] da
);
   localparam int BLK_BIT = REG_AW;
   localparam int SIDE_BIT = REG_AW + 1;

   logic ide_side;

   // IDE side is chosen only inside the window with the side bit low
   assign ide_side = !sel_n && !addr[SIDE_BIT];
   assign cs0_n    = !(ide_side && !addr[BLK_BIT]);
   assign cs1_n    = !(ide_side &&  addr[BLK_BIT]);
   assign da       = addr[REG_AW-1:0];
endmodule

// File: rtl/ide_strobe_gen.sv
module ide_strobe_gen
   import ide_bridge_pkg::*;
#(
   parameter int PHASE_DLY = 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sel_n,
   input  logic      phase,
   input  logic      side_hi,
   input  logic      rnw,
   output acc_kind_e kind
);
   logic phase_q;
   logic active;

   generate
      if (PHASE_DLY == 0) begin : g_nodly
         assign phase_q = phase;
      end else begin : g_dly
         logic [PHASE_DLY-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else if (PHASE_DLY == 1) pipe <= phase;
            else pipe <= {pipe[PHASE_DLY-2:0], phase};
         end
         assign phase_q = pipe[PHASE_DLY-1];
      end
   endgenerate

   assign active = !sel_n && phase_q;

   always_comb begin
      kind = ACC_IDLE;
      if (active) begin
         case ({side_hi, rnw})
            2'b00:   kind = ACC_IDE_WR;
            2'b01:   kind = ACC_IDE_RD;
            2'b10:   kind = ACC_HI_LD;
            default: kind = ACC_HI_RD;
         endcase
      end
   end
endmodule

// File: rtl/ide_hi_latch.sv
module ide_hi_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/ide_byte_bridge.sv
module ide_byte_bridge
   import ide_bridge_pkg::*;
#(
   parameter int HOST_W    = 8,
   parameter int REG_AW    = 3,
   parameter int PHASE_DLY = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hst_sel_n,
   input  logic                hst_phase,
   input  logic                hst_rnw,
   input  logic [REG_AW+1:0]   hst_addr,
   input  logic [HOST_W-1:0]   hst_wdata,
   output logic [HOST_W-1:0]   hst_rdata,
   output logic                hst_rdata_oe,
   output logic                ide_cs0_n,
   output logic                ide_cs1_n,
   output logic [REG_AW-1:0]   ide_da,
   output logic                ide_ior_n,
   output logic                ide_iow_n,
   output logic [2*HOST_W-1:0] ide_dd_out,
   output logic                ide_dd_oe,
   input  logic [2*HOST_W-1:0] ide_dd_in
);
   localparam int IDE_W    = 2 * HOST_W;
   localparam int SIDE_BIT = REG_AW + 1;

   initial begin
      if (HOST_W < 1) $fatal(1, "HOST_W must be at least 1");
      if (REG_AW < 1) $fatal(1, "REG_AW must be at least 1");
      if (PHASE_DLY < 0 || PHASE_DLY > 8) $fatal(1, "PHASE_DLY out of range");
   end

   acc_kind_e          kind;
   logic [HOST_W-1:0]  wr_hi_q;
   logic [HOST_W-1:0]  rd_hi_q;

   ide_addr_dec #(.REG_AW(REG_AW)) i_dec (
      .sel_n (hst_sel_n),
      .addr  (hst_addr),
      .cs0_n (ide_cs0_n),
      .cs1_n (ide_cs1_n),
      .da    (ide_da)
   );

   ide_strobe_gen #(.PHASE_DLY(PHASE_DLY)) i_stb (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_n   (hst_sel_n),
      .phase   (hst_phase),
      .side_hi (hst_addr[SIDE_BIT]),
      .rnw     (hst_rnw),
      .kind    (kind)
   );

   assign ide_iow_n = (kind != ACC_IDE_WR);
   assign ide_ior_n = (kind != ACC_IDE_RD);

   ide_hi_latch #(.W(HOST_W)) i_wr_hi (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (kind == ACC_HI_LD),
      .d     (hst_wdata),
      .q     (wr_hi_q)
   );

   // captures on every cycle of a device read; last value before release wins
   ide_hi_latch #(.W(HOST_W)) i_rd_hi (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (!ide_ior_n),
      .d     (ide_dd_in[IDE_W-1:HOST_W]),
      .q     (rd_hi_q)
   );

   assign ide_dd_oe  = !ide_iow_n;
   assign ide_dd_out = ide_dd_oe ? {wr_hi_q, hst_wdata} : '0;

   always_comb begin
      hst_rdata_oe = 1'b0;
      hst_rdata    = '0;
      case (kind)
         ACC_IDE_RD: begin
            hst_rdata_oe = 1'b1;
            hst_rdata    = ide_dd_in[HOST_W-1:0];
         end
         ACC_HI_RD: begin
            hst_rdata_oe = 1'b1;
            hst_rdata    = rd_hi_q;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/ide_byte_bridge_chk.sv
module ide_byte_bridge_chk #(
   parameter int HOST_W = 8,
   parameter int REG_AW = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                hst_sel_n,
   input logic                hst_rnw,
   input logic [REG_AW+1:0]   hst_addr,
   input logic                hst_rdata_oe,
   input logic                ide_cs0_n,
   input logic                ide_cs1_n,
   input logic                ide_ior_n,
   input logic                ide_iow_n,
   input logic                ide_dd_oe
);
   p_cs_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ide_cs0_n && !ide_cs1_n));

   p_strobe_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ide_ior_n && !ide_iow_n));

   p_strobe_has_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!ide_ior_n || !ide_iow_n) |-> (!ide_cs0_n || !ide_cs1_n));

   p_strobe_needs_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ide_ior_n || !ide_iow_n) |-> !hst_sel_n);

   p_dd_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ide_dd_oe |-> (!ide_iow_n && !hst_rnw));

   p_rdata_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hst_rdata_oe |-> (hst_rnw && !hst_sel_n && ide_iow_n));

   p_cs_side_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_sel_n || hst_addr[REG_AW+1]) |-> (ide_cs0_n && ide_cs1_n));
endmodule

bind ide_byte_bridge ide_byte_bridge_chk #(.HOST_W(HOST_W), .REG_AW(REG_AW)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hst_sel_n    (hst_sel_n),
   .hst_rnw      (hst_rnw),
   .hst_addr     (hst_addr),
   .hst_rdata_oe (hst_rdata_oe),
   .ide_cs0_n    (ide_cs0_n),
   .ide_cs1_n    (ide_cs1_n),
   .ide_ior_n    (ide_ior_n),
   .ide_iow_n    (ide_iow_n),
   .ide_dd_oe    (ide_dd_oe)
);

// File: tb/test_ide_byte_bridge.sv
module test_ide_byte_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_sel_n = 1'b1;
   logic        hst_phase = 1'b0;
   logic        hst_rnw = 1'b1;
   logic [4:0]  hst_addr = '0;
   logic [7:0]  hst_wdata = '0;
   logic [7:0]  hst_rdata;
   logic        hst_rdata_oe;
   logic        ide_cs0_n, ide_cs1_n;
   logic [2:0]  ide_da;
   logic        ide_ior_n, ide_iow_n;
   logic [15:0] ide_dd_out;
   logic        ide_dd_oe;
   logic [15:0] ide_dd_in = '0;

   int n_chk = 0;
   int n_err = 0;
   logic [7:0] m_wr_hi = 8'h00;
   logic [7:0] m_rd_hi = 8'h00;

   always #5 clk = ~clk;

   ide_byte_bridge i_ide_byte_bridge (
      .clk(clk), .rst_n(rst_n), .hst_sel_n(hst_sel_n), .hst_phase(hst_phase),
      .hst_rnw(hst_rnw), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
      .hst_rdata(hst_rdata), .hst_rdata_oe(hst_rdata_oe),
      .ide_cs0_n(ide_cs0_n), .ide_cs1_n(ide_cs1_n), .ide_da(ide_da),
      .ide_ior_n(ide_ior_n), .ide_iow_n(ide_iow_n), .ide_dd_out(ide_dd_out),
      .ide_dd_oe(ide_dd_oe), .ide_dd_in(ide_dd_in)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // one complete host access: setup, strobe phase, release
   task automatic access(input logic rnw, input logic [4:0] a, input logic [7:0] wd,
                         input logic [15:0] din);
      logic ide_side;
      logic [1:0] e_cs;
      logic e_iow, e_ior, e_roe;
      logic [7:0] e_rd;
      ide_side = !a[4];
      e_cs  = ide_side ? (a[3] ? 2'b01 : 2'b10) : 2'b11; // {cs1_n,cs0_n}
      e_iow = !(ide_side && !rnw);
      e_ior = !(ide_side && rnw);
      e_roe = rnw;
      e_rd  = !rnw ? 8'h00 : (ide_side ? din[7:0] : m_rd_hi);
      @(negedge clk);
      hst_sel_n = 1'b0; hst_rnw = rnw; hst_addr = a; hst_wdata = wd;
      ide_dd_in = din; hst_phase = 1'b1;
      #1;
      chk("R1 cs", {30'd0, ide_cs1_n, ide_cs0_n}, {30'd0, e_cs});
      chk("R1 da", {29'd0, ide_da}, {29'd0, a[2:0]});
      chk("R3 no early strobe", {30'd0, ide_iow_n, ide_ior_n}, 32'd3);
      @(negedge clk);
      chk("R4 strobes", {30'd0, ide_iow_n, ide_ior_n}, {30'd0, e_iow, e_ior});
      chk("R5 dd_oe", {31'd0, ide_dd_oe}, {31'd0, !e_iow});
      chk("R5 dd_out", {16'd0, ide_dd_out}, !e_iow ? {16'd0, m_wr_hi, wd} : 32'd0);
      chk("R8 rdata_oe", {31'd0, hst_rdata_oe}, {31'd0, e_roe});
      chk(ide_side ? "R8 rdata" : "R7 rdata hi", {24'd0, hst_rdata}, {24'd0, e_rd});
      hst_phase = 1'b0;
      @(negedge clk);
      chk("R3 strobe release", {30'd0, ide_iow_n, ide_ior_n}, 32'd3);
      hst_sel_n = 1'b1;
      if (!ide_side && !rnw) m_wr_hi = wd;       // R6
      if (ide_side && rnw) m_rd_hi = din[15:8];  // R7
   endtask

   initial begin
      #3000000;
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 strobes", {30'd0, ide_iow_n, ide_ior_n}, 32'd3);
      chk("R10 dd_oe", {31'd0, ide_dd_oe}, 32'd0);
      rst_n = 1'b1;
      access(1'b1, 5'h10, 8'h00, 16'h0000); // R10 read-high holder is 0
      access(1'b0, 5'h00, 8'h5A, 16'h0000); // R10 write-high holder is 0 (dd_out hi)
      // R2/R3 phase toggles while deselected
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); hst_phase = 1'b1; hst_addr = 5'(i * 3);
         @(negedge clk);
         chk("R2 cs idle", {30'd0, ide_cs1_n, ide_cs0_n}, 32'd3);
         chk("R3 no strobe unselected", {30'd0, ide_iow_n, ide_ior_n}, 32'd3);
         hst_phase = 1'b0;
      end
      // exhaustive sweep, two data patterns
      for (int p = 0; p < 2; p++) begin
         for (int a = 0; a < 32; a++) begin
            for (int r = 0; r < 2; r++) begin
               access(r[0], a[4:0], 8'((a * 37 + r * 11 + p * 91) ^ 8'hA5),
                      16'((a * 4099 + p * 777 + r * 13) ^ 16'h3C96));
            end
         end
      end
      // R6 latch write then IDE write shows new high byte
      access(1'b0, 5'h11, 8'hC3, 16'h0);
      access(1'b0, 5'h08, 8'h7E, 16'h0);
      // R7 read, then latch read returns captured byte
      access(1'b1, 5'h00, 8'h00, 16'hBEEF);
      access(1'b1, 5'h10, 8'h00, 16'h0000);
      // R3 select release mid-access clears strobe immediately
      @(negedge clk);
      hst_sel_n = 1'b0; hst_rnw = 1'b1; hst_addr = 5'h07; hst_phase = 1'b1;
      @(negedge clk);
      chk("R3 strobe active", {31'd0, ide_ior_n}, 32'd0);
      hst_sel_n = 1'b1; #1;
      chk("R3 sel release", {31'd0, ide_ior_n}, 32'd1);
      chk("R2 cs after release", {30'd0, ide_cs1_n, ide_cs0_n}, 32'd3);
      hst_phase = 1'b0;
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule